// File: doc/BRIEF.md
# Four-State Table Machine with Paired Mealy and Moore Outputs

This block holds one fixed four-state sequential machine with a single input bit `x` and a single output bit, built two ways side by side. The Mealy form keeps two state bits and derives its output combinationally from the present state and the present input. The Moore form keeps a wider state in which each state of the Mealy form is split according to the output value it was entered with. Its output depends on that state alone, so it is a glitch-free registered copy of the same behaviour, one clock later.

Both forms share the clock, the active-low asynchronous reset and the input. A design can use either output: the Mealy one for same-cycle response, the Moore one where a registered output is needed and one cycle of latency is acceptable.

Top module: `tableFsmPair`

## Requirements
- R1: While reset is held and in the first cycle after its release, `mealyState` is 0 (state A) and `zMoore` is 0.
- R2: State codes are A=0, B=1, C=2, D=3. At each rising clock edge out of reset, the Mealy state moves A→C (x=0) or B (x=1); B→A (x=0) or D (x=1); C→B (x=0) or A (x=1); D→D (x=0) or C (x=1).
- R3: `zMealy` is a combinational function of the present state and `x`: it is 1 for B with x=0, for C with either x, and for D with x=0; it is 0 for A with either x, for B with x=1 and for D with x=1. A change of `x` within a cycle shows on `zMealy` without a clock edge.
- R4: The Moore form starts in a state of its own whose output is 0, so `zMoore` is 0 in the cycle after reset release whatever `x` is.
- R5: From the second cycle after reset release, `zMoore` in each cycle equals the value `zMealy` had just before the preceding rising edge.
- R6: A change of `x` within a cycle has no effect on `zMoore`.
- R7: Asserting reset in the middle of a run forces state A and `zMoore` = 0 at once, without waiting for a clock edge.
- R8: Held in D with x=0, the machine stays in D and both outputs remain 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| x | input | 1 | Machine input bit |
| zMealy | output | 1 | Output of the Mealy form, combinational from state and input |
| zMoore | output | 1 | Output of the Moore form, a function of its state only |
| mealyState | output | 2 | Present Mealy state code (A=0, B=1, C=2, D=3) |

## Verification
The awkward case is the Moore form being correct only on average: a split state that is reached along just one path, such as D entered with output 0 from B, or A entered with output 1 from C, would hide a wrong successor under short random runs. The bench therefore resets and replays every 8-bit input sequence, which drives every Mealy state through both input values at several depths and enters all seven Moore states along every path that leads to them. Within each cycle the input is flipped and flipped back before the edge, so the combinational path of the Mealy output and the insensitivity of the Moore output are both observed.

// File: rtl/tableFsmPkg.sv
package tableFsmPkg;

  localparam int MEALY_W = 2;
  localparam int MOORE_W = 3;

  typedef enum logic [MEALY_W-1:0] {
    ST_A = 2'd0,
    ST_B = 2'd1,
    ST_C = 2'd2,
    ST_D = 2'd3
  } mealyStT;

  // Moore states: Mealy state paired with the output it was entered with.
  typedef enum logic [MOORE_W-1:0] {
    MS_A0 = 3'd0,
    MS_A1 = 3'd1,
    MS_B0 = 3'd2,
    MS_B1 = 3'd3,
    MS_C0 = 3'd4,
    MS_D0 = 3'd5,
    MS_D1 = 3'd6
  } mooreStT;

  // Strobes from the Mealy control toward the top.
  typedef struct packed {
    mealyStT cur;
    mealyStT nxt;
    logic    z;
  } stepT;

endpackage

// File: rtl/mealyCtrl.sv
module mealyCtrl
  import tableFsmPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic x,
  output stepT step
);

  mealyStT stateQ;
  mealyStT stateD;
  logic    zOut;

  always_comb begin
    stateD = stateQ;
    zOut   = 1'b0;
    unique case (stateQ)
      ST_A: begin stateD = x ? ST_B : ST_C; zOut = 1'b0; end
      ST_B: begin stateD = x ? ST_D : ST_A; zOut = ~x;   end
      ST_C: begin stateD = x ? ST_A : ST_B; zOut = 1'b1; end
      ST_D: begin stateD = x ? ST_C : ST_D; zOut = ~x;   end
      default: begin stateD = ST_A; zOut = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_A;
    else       stateQ <= stateD;
  end

  always_comb begin
    step.cur = stateQ;
    step.nxt = stateD;
    step.z   = zOut;
  end

endmodule

// File: rtl/mooreDp.sv
module mooreDp
  import tableFsmPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic x,
  output logic zMoore
);

  mooreStT stateQ;
  mooreStT stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      MS_A0, MS_A1: stateD = x ? MS_B0 : MS_C0;
      MS_B0, MS_B1: stateD = x ? MS_D0 : MS_A1;
      MS_C0:        stateD = x ? MS_A1 : MS_B1;
      MS_D0, MS_D1: stateD = x ? MS_C0 : MS_D1;
      default:      stateD = MS_A0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= MS_A0;
    else       stateQ <= stateD;
  end

  always_comb begin
    unique case (stateQ)
      MS_A1, MS_B1, MS_D1: zMoore = 1'b1;
      default:             zMoore = 1'b0;
    endcase
  end

endmodule

// File: rtl/tableFsmPair.sv
module tableFsmPair
  import tableFsmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       x,
  output logic       zMealy,
  output logic       zMoore,
  output logic [1:0] mealyState
);

  stepT step;

  mealyCtrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .x    (x),
    .step (step)
  );

  mooreDp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .x      (x),
    .zMoore (zMoore)
  );

  assign zMealy     = step.z;
  assign mealyState = step.cur;

endmodule

// File: rtl/tableFsmPairChk.sv
module tableFsmPairChk (
  input logic       clk,
  input logic       rstN,
  input logic       x,
  input logic       zMealy,
  input logic       zMoore,
  input logic [1:0] mealyState
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  function automatic logic [1:0] expNext(input logic [1:0] s, input logic b);
    case (s)
      2'd0:    expNext = b ? 2'd1 : 2'd2;
      2'd1:    expNext = b ? 2'd3 : 2'd0;
      2'd2:    expNext = b ? 2'd0 : 2'd1;
      default: expNext = b ? 2'd2 : 2'd3;
    endcase
  endfunction

  function automatic logic expOut(input logic [1:0] s, input logic b);
    case (s)
      2'd0:    expOut = 1'b0;
      2'd1:    expOut = ~b;
      2'd2:    expOut = 1'b1;
      default: expOut = ~b;
    endcase
  endfunction

  assert_mealy_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> mealyState == expNext($past(mealyState), $past(x)));

  assert_mealy_out_R3: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> zMealy == expOut(mealyState, x));

  assert_moore_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> zMoore == $past(zMealy));

  assert_moore_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !zMoore);

  assert_d_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(mealyState) == 2'd3 && !$past(x)) |-> (mealyState == 2'd3 && zMoore));

endmodule

bind tableFsmPair tableFsmPairChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .x          (x),
  .zMealy     (zMealy),
  .zMoore     (zMoore),
  .mealyState (mealyState)
);

// File: tb/tableFsmPair_bench.sv
module tableFsmPair_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       x = 1'b0;
  logic       zMealy;
  logic       zMoore;
  logic [1:0] mealyState;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] refState;
  logic       refMoore;

  always #10 clk = ~clk;

  tableFsmPair u_tableFsmPair (
    .clk        (clk),
    .rstN       (rstN),
    .x          (x),
    .zMealy     (zMealy),
    .zMoore     (zMoore),
    .mealyState (mealyState)
  );

  function automatic logic [1:0] refNext(input logic [1:0] s, input logic b);
    case (s)
      2'd0:    return b ? 2'd1 : 2'd2;
      2'd1:    return b ? 2'd3 : 2'd0;
      2'd2:    return b ? 2'd0 : 2'd1;
      default: return b ? 2'd2 : 2'd3;
    endcase
  endfunction

  function automatic logic refOut(input logic [1:0] s, input logic b);
    case (s)
      2'd0:    return 1'b0;
      2'd1:    return ~b;
      2'd2:    return 1'b1;
      default: return ~b;
    endcase
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R7 state", mealyState, 2'd0);
    chk("R7 zMoore", {1'b0, zMoore}, 2'd0);
    @(posedge clk);
    chk("R1 state in reset", mealyState, 2'd0);
    @(negedge clk);
    rstN = 1'b1;
    x = 1'b1;
    #1;
    refState = 2'd0;
    refMoore = 1'b0;
    chk("R1 state after release", mealyState, 2'd0);
    chk("R4 zMoore first cycle", {1'b0, zMoore}, 2'd0);
  endtask

  // Called just after a falling edge; leaves x = b before the next rising edge.
  task automatic stepOne(input logic b);
    logic mooreHold;
    x = ~b;
    #1;
    chk("R3 zMealy other x", {1'b0, zMealy}, {1'b0, refOut(refState, ~b)});
    mooreHold = zMoore;
    x = b;
    #1;
    chk("R3 zMealy", {1'b0, zMealy}, {1'b0, refOut(refState, b)});
    chk("R6 zMoore unaffected by x", {1'b0, zMoore}, {1'b0, mooreHold});
    chk("R5 zMoore delayed", {1'b0, zMoore}, {1'b0, refMoore});
    chk("R2 state", mealyState, refState);
    refMoore = refOut(refState, b);
    refState = refNext(refState, b);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    refState = 2'd0;
    refMoore = 1'b0;
    // all 8-bit input sequences, each from reset
    for (int s = 0; s < 256; s++) begin
      logic [7:0] pat;
      pat = s[7:0];
      doReset();
      for (int i = 0; i < 8; i++) stepOne(pat[i]);
    end
    // R8: reach D via A-x1->B-x1->D, then hold x=0
    doReset();
    stepOne(1'b1);
    stepOne(1'b1);
    for (int k = 0; k < 6; k++) begin
      x = 1'b0;
      #1;
      chk("R8 state D", mealyState, 2'd3);
      chk("R8 zMealy", {1'b0, zMealy}, 2'd1);
      if (k > 0) chk("R8 zMoore", {1'b0, zMoore}, 2'd1);
      stepOne(1'b0);
    end
    // long mixed run with a mid-run reset (R7)
    doReset();
    for (int k = 0; k < 300; k++) stepOne(((k * 7) % 5) > 1);
    doReset();
    for (int k = 0; k < 20; k++) stepOne(k[0] ^ k[2]);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule